// File: doc/BRIEF.md
# Programmable Flag Offset Register Port

This block sits beside a clocked buffer memory and holds the two thresholds that its almost-empty and almost-full flag logic compares against. Software loads and reads these thresholds over the buffer's ordinary data path. No separate configuration bus is used. A shared pin selects how the port behaves. It doubles as a second write enable for the buffer, or acts as a load strobe for the threshold registers. Its level is captured while reset is held, and only another reset changes it.

In load mode each qualifying write-clock edge stores one data word into the next threshold part. Each threshold is split into a low part and a high part. A two-bit pointer visits four parts in a fixed cycle and wraps around. Read-back uses its own pointer on the read clock and walks the same cycle. Each qualifying read-clock edge places one part on a registered data output. Both thresholds leave reset at 7.

Data accesses are plain enable strobes. There is no back-pressure: the port accepts a qualifying write on every edge, and a qualifying read always yields a word on the next edge. Reading and writing the registers on the same edge is a usage error. The write wins, the read is dropped, and a one-cycle error pulse marks it.

Top module: `flag_ofs_port`

## Requirements
- R1: The level of `wen2_ld_n` at the last write-clock edge with `rst_n` low sets the mode. Low means load mode, shown as `ld_mode`=1. High means normal mode, shown as `ld_mode`=0. The mode holds until the next reset.
- R2: Reset sets both `ae_ofs` and `af_ofs` to 7, `rd_data` to 0 and `rd_clash_err` to 0. It also points both sequencing pointers at the first part, so the first read after reset returns the almost-empty low part.
- R3: A write-clock edge stores exactly one part when three things hold: the port is in load mode, `wen2_ld_n` is low and `wen1_n` is low. If `wen2_ld_n` is high, no part is stored.
- R4: Successive writes go to four parts in this order: select 0 is almost-empty low, select 1 is almost-empty high, select 2 is almost-full low, select 3 is almost-full high. The fifth write goes back to select 0.
- R5: A low part stores `wdata` bits [min(OFS_W,DATA_W)-1:0] into the same offset bits. A high part stores the offset bits above DATA_W from the bottom of `wdata`. If OFS_W <= DATA_W, a high-part write still advances the pointer but changes no offset.
- R6: A read-clock edge loads `rd_data` with the part at the read pointer and advances the pointer in the same four-step cyclic order when all of these hold: the port is in load mode, `wen2_ld_n` is low, `ren1_n` and `ren2_n` are both low, and `wen1_n` is high. The value is zero-extended. A high part returns the offset bits above DATA_W.
- R7: On any other read-clock edge, `rd_data` and the read pointer keep their values. This includes an edge where only one read enable is low.
- R8: If a load-mode write and a read request arrive on the same edge, the write is performed and the read is dropped. `rd_data` and the read pointer stay unchanged, and `rd_clash_err` is high for the following cycle.
- R9: In normal mode no pin pattern changes the offsets, `rd_data` or `rd_clash_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wen1_n | input | 1 | Write enable 1, active low |
| wen2_ld_n | input | 1 | Write enable 2 or load strobe, active low, mode sampled in reset |
| wdata | input | DATA_W | Buffer write data |
| ren1_n | input | 1 | Read enable 1, active low |
| ren2_n | input | 1 | Read enable 2, active low |
| ld_mode | output | 1 | 1 when the shared pin is a load strobe |
| ae_ofs | output | OFS_W | Almost-empty threshold to flag logic |
| af_ofs | output | OFS_W | Almost-full threshold to flag logic |
| rd_data | output | DATA_W | Registered read-back word |
| rd_clash_err | output | 1 | One-cycle pulse after a same-edge read and write |

## Verification
The bench builds two copies that share the same pins. The first copy uses DEPTH=256, which gives an 8-bit offset that fits inside the 9-bit data word. With it the bench can check that a high-part write is accepted but has no effect, and that the ninth data bit is dropped. The second copy uses DEPTH=2048, which gives an 11-bit offset. With it the high part carries two real bits and reads them back, so the split of an offset across both parts is exercised. Both clocks are tied together, so clashes between reading and writing on one edge can be produced on purpose.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    SEL_AE_LO = 2'd0,
    SEL_AE_HI = 2'd1,
    SEL_AF_LO = 2'd2,
    SEL_AF_HI = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/ofs_mode_cap.sv
module ofs_mode_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_n,
  output logic ld_mode
);
  // the shared pin is sampled on every edge while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) ld_mode <= ~ld_n;
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(ld_mode)); // R1
endmodule

// File: rtl/ofs_step_ptr.sv
module ofs_step_ptr
  import ofs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  output ofs_sel_e sel
);
  logic [1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= 2'd0;
    else if (adv) cnt <= cnt + 2'd1;
  end

  assign sel = ofs_sel_e'(cnt);

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (sel == ofs_sel_e'($past(cnt) + 2'd1))); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(sel)); // R7
endmodule

// File: rtl/ofs_regfile.sv
module ofs_regfile
  import ofs_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int OFS_W   = 8,
  parameter int DEF_OFS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  ofs_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [OFS_W-1:0]  ae,
  output logic [OFS_W-1:0]  af
);
  localparam int LO_W = (OFS_W < DATA_W) ? OFS_W : DATA_W;
  localparam int HI_W = OFS_W - LO_W;
  localparam logic [OFS_W-1:0] LO_MASK = OFS_W'((64'd1 << LO_W) - 64'd1);
  localparam logic [OFS_W-1:0] DEF_V   = OFS_W'(DEF_OFS);

  logic [OFS_W-1:0] lo_val, hi_val, ae_nxt, af_nxt;

  assign lo_val = OFS_W'(wdata[LO_W-1:0]);

  generate
    if (HI_W > 0) begin : g_hi
      assign hi_val = {wdata[HI_W-1:0], {LO_W{1'b0}}};
    end else begin : g_no_hi
      assign hi_val = '0;
    end
  endgenerate

  wire unused_wdata = ^wdata;

  always_comb begin
    ae_nxt = ae;
    af_nxt = af;
    unique case (sel)
      SEL_AE_LO: ae_nxt = (ae & ~LO_MASK) | lo_val;
      SEL_AE_HI: ae_nxt = (ae &  LO_MASK) | hi_val;
      SEL_AF_LO: af_nxt = (af & ~LO_MASK) | lo_val;
      SEL_AF_HI: af_nxt = (af &  LO_MASK) | hi_val;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ae <= DEF_V;
      af <= DEF_V;
    end else if (wr_en) begin
      ae <= ae_nxt;
      af <= af_nxt;
    end
  end

  AST_NO_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ae) && $stable(af))); // R9
  AST_ONE_PART: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_AE_LO || sel == SEL_AE_HI)) |=> $stable(af)); // R3

  generate
    if (HI_W == 0) begin : g_hi_chk
      AST_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_AE_HI || sel == SEL_AF_HI)) |=> ($stable(ae) && $stable(af))); // R5
    end
  endgenerate
endmodule

// File: rtl/ofs_rd_mux.sv
module ofs_rd_mux
  import ofs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  ofs_sel_e          sel,
  input  logic [OFS_W-1:0]  ae,
  input  logic [OFS_W-1:0]  af,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LO_W = (OFS_W < DATA_W) ? OFS_W : DATA_W;
  localparam logic [OFS_W-1:0] LO_MASK = OFS_W'((64'd1 << LO_W) - 64'd1);

  logic [DATA_W-1:0] part;

  always_comb begin
    unique case (sel)
      SEL_AE_LO: part = DATA_W'(ae & LO_MASK);
      SEL_AE_HI: part = DATA_W'(ae >> LO_W);
      SEL_AF_LO: part = DATA_W'(af & LO_MASK);
      SEL_AF_HI: part = DATA_W'(af >> LO_W);
      default:   part = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= part;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R7
endmodule

// File: rtl/flag_ofs_port.sv
module flag_ofs_port
  import ofs_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int DATA_W  = 9,
  parameter int DEF_OFS = 7,
  localparam int OFS_W  = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wen1_n,
  input  logic              wen2_ld_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ren1_n,
  input  logic              ren2_n,
  output logic              ld_mode,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_clash_err
);
  logic     ld_mode_r;
  logic     wr_go, rd_req, rd_go;
  ofs_sel_e wsel, rsel;

  ofs_mode_cap u_mode_w (.clk(wclk), .rst_n(rst_n), .ld_n(wen2_ld_n), .ld_mode(ld_mode));
  ofs_mode_cap u_mode_r (.clk(rclk), .rst_n(rst_n), .ld_n(wen2_ld_n), .ld_mode(ld_mode_r));

  assign wr_go  = ld_mode & ~wen2_ld_n & ~wen1_n;
  assign rd_req = ~wen2_ld_n & ~ren1_n & ~ren2_n;
  // a write on the same edge takes precedence over read-back
  assign rd_go  = ld_mode_r & rd_req & wen1_n;

  ofs_step_ptr u_wptr (.clk(wclk), .rst_n(rst_n), .adv(wr_go), .sel(wsel));
  ofs_step_ptr u_rptr (.clk(rclk), .rst_n(rst_n), .adv(rd_go), .sel(rsel));

  ofs_regfile #(.DATA_W(DATA_W), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_regs (
    .clk(wclk), .rst_n(rst_n), .wr_en(wr_go), .sel(wsel), .wdata(wdata),
    .ae(ae_ofs), .af(af_ofs));

  ofs_rd_mux #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rdmux (
    .clk(rclk), .rst_n(rst_n), .rd_en(rd_go), .sel(rsel),
    .ae(ae_ofs), .af(af_ofs), .rd_data(rd_data));

  always_ff @(posedge wclk) begin
    if (!rst_n) rd_clash_err <= 1'b0;
    else        rd_clash_err <= wr_go & rd_req;
  end

  AST_CLASH_FLAG: assert property (@(posedge wclk) disable iff (!rst_n)
    (ld_mode && !wen1_n && !wen2_ld_n && !ren1_n && !ren2_n) |=> rd_clash_err); // R8
  AST_CLASH_NO_READ: assert property (@(posedge rclk) disable iff (!rst_n)
    (ld_mode_r && !wen1_n && !wen2_ld_n && !ren1_n && !ren2_n) |=> $stable(rd_data)); // R8
  AST_NORMAL_QUIET: assert property (@(posedge wclk) disable iff (!rst_n)
    !ld_mode |=> (!rd_clash_err && $stable(ae_ofs) && $stable(af_ofs))); // R9
endmodule

// File: tb/flag_ofs_port_tb.sv
module flag_ofs_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wen1_n = 1'b1, ld_n = 1'b0, ren1_n = 1'b1, ren2_n = 1'b1;
  logic [8:0] wdata = '0;

  logic        ld_mode, err, ld_mode_w, err_w;
  logic [7:0]  ae, af;
  logic [10:0] ae_w, af_w;
  logic [8:0]  rdd, rdd_w;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  flag_ofs_port #(.DEPTH(256)) dut_i (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld_n(ld_n),
    .wdata(wdata), .ren1_n(ren1_n), .ren2_n(ren2_n), .ld_mode(ld_mode),
    .ae_ofs(ae), .af_ofs(af), .rd_data(rdd), .rd_clash_err(err));

  flag_ofs_port #(.DEPTH(2048)) dut_w (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld_n(ld_n),
    .wdata(wdata), .ren1_n(ren1_n), .ren2_n(ren2_n), .ld_mode(ld_mode_w),
    .ae_ofs(ae_w), .af_ofs(af_w), .rd_data(rdd_w), .rd_clash_err(err_w));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic ld_lvl);
    @(negedge clk);
    rst_n = 1'b0; ld_n = ld_lvl; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [8:0] d);
    wdata = d; wen1_n = 1'b0;
    @(negedge clk);
    wen1_n = 1'b1;
  endtask

  task automatic rd();
    ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge clk);
    ren1_n = 1'b1; ren2_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1 load mode", 16'(ld_mode), 16'd1);
    chk("R2 ae default", 16'(ae), 16'd7);
    chk("R2 af default", 16'(af), 16'd7);
    chk("R2 wide ae default", 16'(ae_w), 16'd7);
    chk("R2 rd_data reset", 16'(rdd), 16'd0);
    chk("R2 err reset", 16'(err), 16'd0);
    rd();
    chk("R2 first read is ae low", 16'(rdd), 16'd7);
    wr(9'h033);
    chk("R2 first write is ae low", 16'(ae), 16'h33);
    do_reset(1'b0);
    chk("R2 reset restores ae", 16'(ae), 16'd7);
  endtask

  task automatic t_load_readback();
    do_reset(1'b0);
    ld_n = 1'b1;
    wr(9'h0AA);
    ld_n = 1'b0;
    chk("R3 no store with load pin high", 16'(ae), 16'd7);
    wr(9'h1A5);
    chk("R3 ae low stored", 16'(ae), 16'hA5);
    chk("R3 af untouched", 16'(af), 16'd7);
    wr(9'h0F3);
    chk("R5 narrow high ignored", 16'(ae), 16'hA5);
    chk("R5 wide high stored", 16'(ae_w), 16'h7A5);
    wr(9'h13C);
    wr(9'h1FF);
    chk("R4 af low third", 16'(af), 16'h3C);
    chk("R4 wide af", 16'(af_w), 16'h73C);
    rd(); chk("R6 read ae lo", 16'(rdd), 16'h0A5); chk("R6 wide ae lo", 16'(rdd_w), 16'h1A5);
    rd(); chk("R6 read ae hi", 16'(rdd), 16'h000); chk("R6 wide ae hi", 16'(rdd_w), 16'h003);
    rd(); chk("R6 read af lo", 16'(rdd), 16'h03C); chk("R6 wide af lo", 16'(rdd_w), 16'h13C);
    rd(); chk("R6 read af hi", 16'(rdd), 16'h000); chk("R6 wide af hi", 16'(rdd_w), 16'h003);
    rd(); chk("R6 read wraps", 16'(rdd), 16'h0A5);
    @(negedge clk);
    chk("R7 idle hold", 16'(rdd), 16'h0A5);
    ren1_n = 1'b0;
    @(negedge clk);
    ren1_n = 1'b1;
    chk("R7 one enable hold", 16'(rdd), 16'h0A5);
    rd(); chk("R7 pointer held then ae hi", 16'(rdd_w), 16'h003);
    wr(9'h011);
    chk("R4 write wraps to ae lo", 16'(ae), 16'h11);
    chk("R4 wide wrap", 16'(ae_w), 16'h611);
  endtask

  task automatic t_clash();
    do_reset(1'b0);
    wr(9'h020); wr(9'h000); wr(9'h030); wr(9'h000);
    rd(); rd(); rd(); rd();
    wdata = 9'h055; wen1_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge clk);
    wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    chk("R8 write wins", 16'(ae), 16'h55);
    chk("R8 read dropped", 16'(rdd), 16'h000);
    chk("R8 err raised", 16'(err), 16'd1);
    @(negedge clk);
    chk("R8 err one cycle", 16'(err), 16'd0);
    rd();
    chk("R8 read pointer held", 16'(rdd), 16'h055);
  endtask

  task automatic t_normal();
    do_reset(1'b1);
    chk("R1 normal mode", 16'(ld_mode), 16'd0);
    ld_n = 1'b0; wdata = 9'h0AA; wen1_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
    repeat (3) @(negedge clk);
    wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    chk("R9 ae unchanged", 16'(ae), 16'd7);
    chk("R9 af unchanged", 16'(af), 16'd7);
    chk("R9 rd_data unchanged", 16'(rdd), 16'd0);
    chk("R9 no err", 16'(err), 16'd0);
    chk("R1 mode still normal", 16'(ld_mode_w), 16'd0);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_load_readback();
    t_clash();
    t_normal();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule